// File: doc/BRIEF.md
# Sequential Max-Star Add-Compare-Select Unit

This block is the arithmetic core of a log-domain soft-output trellis decoder. Each clock it performs at most one operation, chosen by a two-bit opcode: a plain addition, a plain subtraction, or one add-compare-select step. An add-compare-select step adds a branch metric to a path metric. It then merges the sum into a running value by taking the larger of the two and adding a small correction read from a table. That correction brings the result closer to the exact Jacobian logarithm than a bare maximum does.

Four consecutive add-compare-select steps make one group, which reduces four terms to a single max-star value. A strobe marks the cycle in which that group result is on the output. Three private registers keep intermediate values from one cycle to a later one. Any operation can write its result into one of them, and any operation can take its first operand from one of them instead of from the input port. The trellis controller sequences the opcodes and the main memory supplies metrics. Both lie outside this block.

Metrics are 10-bit two's complement numbers with two fraction bits, so one LSB is 0.25. The magnitude of the difference that indexes the correction table is approximated by bit inversion instead of a true negation. The table contents absorb the resulting one-LSB bias.

Top module: `acs_maxstar_unit`

## Requirements
- R1: After reset the result output is 0, the strobe is low, the group position is at the first step and registers R1 to R3 all read as 0.
- R2: Opcode 01 (add) puts sat(A + opb_i) on res_o in the cycle after it is presented. When dst_i is 1, 2 or 3, every non-NOP operation also writes its result into R1, R2 or R3 at the same edge. dst_i = 0 writes nothing.
- R3: Opcode 10 (subtract) puts sat(A - opb_i) on res_o in the cycle after it is presented.
- R4: Every sum, difference and corrected maximum clamps to +511 or -512 instead of wrapping.
- R5: The first operand A is opa_i when asel_i = 0, and is R1, R2 or R3 when asel_i is 1, 2 or 3. A value written at one edge is seen by the operation in the next cycle.
- R6: Opcode 11 at the first step of a group sets both the running value and res_o to T = sat(A + bm_i), discarding the previous group.
- R7: Opcode 11 at steps two to four sets the running value and res_o to sat(max(V, T) + c), with V the running value and D = V - T. The index is k = D when D >= 0 and k = -D - 1 otherwise. c is 3, 2, 2, 1, 1, 1, 1, 1 for k = 0 to 7, and 0 for k > 7.
- R8: done_o is high for exactly one cycle, the cycle after the fourth step of a group, while res_o holds that group's result. An opcode 11 in that cycle starts the next group.
- R9: Opcode 00 (NOP) leaves res_o, the registers, the running value and the group position unchanged, and done_o is low in the following cycle.
- R10: Add and subtract operations issued between the steps of a group change neither the running value nor the group position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_i | input | 2 | Opcode: 00 NOP, 01 add, 10 subtract, 11 add-compare-select |
| asel_i | input | 2 | First operand source: 0 opa_i, 1 to 3 register R1 to R3 |
| dst_i | input | 2 | Result destination: 0 none, 1 to 3 register R1 to R3 |
| opa_i | input | 10 | First operand from outside |
| opb_i | input | 10 | Second operand for add and subtract |
| bm_i | input | 10 | Branch metric for add-compare-select |
| res_o | output | 10 | Registered result of the last operation |
| done_o | output | 1 | One-cycle strobe carrying a finished group result |

## Verification
Two events can fall in the same cycle: the strobe of a finished group, and the first step of the next group, which must restart the running value instead of merging into it. The bench provokes this by issuing back-to-back groups with no idle cycle between them. It also reads a register in the cycle right after the operation that wrote it, and interleaves add and subtract operations inside a group. A behavioural model built on integers predicts res_o and done_o for every cycle, including the edges of the correction index (k = 7 against k = 8 on both signs of D) and the saturation limits. Every cycle's outputs are compared against that model.

// File: rtl/acs_pkg.sv
package acs_pkg;
  typedef enum logic [1:0] {
    OP_NOP = 2'b00,
    OP_ADD = 2'b01,
    OP_SUB = 2'b10,
    OP_ACS = 2'b11
  } acs_op_e;
endpackage

// File: rtl/acs_sat_add.sv
// Saturating signed add or subtract of two W-bit values.
module acs_sat_add #(
  parameter int W = 10
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  input  logic                sub,
  output logic signed [W-1:0] y
);
  logic signed [W:0] a_ext, b_ext, sum;

  always_comb begin
    a_ext = {a[W-1], a};
    b_ext = sub ? -{b[W-1], b} : {b[W-1], b};
    sum   = a_ext + b_ext;
    if (sum[W] != sum[W-1]) begin
      y = sum[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    end else begin
      y = sum[W-1:0];
    end
  end
endmodule

// File: rtl/acs_maxstar.sv
// Corrected maximum of two metrics with an inverted-bit magnitude estimate.
module acs_maxstar #(
  parameter int W = 10
) (
  input  logic signed [W-1:0] x,
  input  logic signed [W-1:0] y,
  output logic signed [W-1:0] z
);
  localparam int IDXW = 3;

  logic signed [W:0]   diff;
  logic        [W:0]   mag;
  logic                far;
  logic        [1:0]   corr;
  logic signed [W-1:0] bigger;
  logic signed [W-1:0] corr_ext;

  // Entries sit at the midpoint between the two true distances an index can mean.
  function automatic logic [1:0] corr_lut(input logic [IDXW-1:0] k);
    case (k)
      3'd0:    corr_lut = 2'd3;
      3'd1:    corr_lut = 2'd2;
      3'd2:    corr_lut = 2'd2;
      default: corr_lut = 2'd1;
    endcase
  endfunction

  always_comb begin
    diff     = {x[W-1], x} - {y[W-1], y};
    mag      = diff[W] ? ~diff : diff;
    far      = |mag[W:IDXW];
    corr     = far ? 2'd0 : corr_lut(mag[IDXW-1:0]);
    bigger   = diff[W] ? y : x;
    corr_ext = {{(W-2){1'b0}}, corr};
  end

  acs_sat_add #(.W(W)) u_corr (
    .a   (bigger),
    .b   (corr_ext),
    .sub (1'b0),
    .y   (z)
  );
endmodule

// File: rtl/acs_regs.sv
// Private scratch registers; select value 0 means none.
module acs_regs #(
  parameter int W    = 10,
  parameter int N    = 3,
  parameter int SELW = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SELW-1:0]     wr_sel,
  input  logic signed [W-1:0] wr_data,
  input  logic [SELW-1:0]     rd_sel,
  input  logic signed [W-1:0] rd_ext,
  output logic signed [W-1:0] rd_data
);
  logic signed [W-1:0] q [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    logic wr_en;
    assign wr_en = (wr_sel == SELW'(g + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[g] <= '0;
      end else if (wr_en) begin
        q[g] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = rd_ext;
    for (int i = 0; i < N; i++) begin
      if (rd_sel == SELW'(i + 1)) rd_data = q[i];
    end
  end
endmodule

// File: rtl/acs_maxstar_unit.sv
module acs_maxstar_unit #(
  parameter int W    = 10,
  parameter int GRP  = 4,
  parameter int NREG = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   op_i,
  input  logic [1:0]   asel_i,
  input  logic [1:0]   dst_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic [W-1:0] bm_i,
  output logic [W-1:0] res_o,
  output logic         done_o
);
  import acs_pkg::*;

  localparam int CW   = (GRP > 1) ? $clog2(GRP) : 1;
  localparam int SELW = 2;

  logic [1:0]          rst_sync;
  logic                rst_ni;
  acs_op_e             op;
  logic signed [W-1:0] a_val, alu_b, alu_y, ms_y;
  logic signed [W-1:0] res_q, res_d, acc_q, acc_d;
  logic [CW-1:0]       cnt_q, cnt_d;
  logic                done_q, done_d, res_en, acs_en;
  logic [SELW-1:0]     wr_sel;

  // Reset asserts at once and is released two clocks later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  assign op = acs_op_e'(op_i);

  acs_regs #(.W(W), .N(NREG), .SELW(SELW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_ni),
    .wr_sel  (wr_sel),
    .wr_data (res_d),
    .rd_sel  (asel_i),
    .rd_ext  (opa_i),
    .rd_data (a_val)
  );

  assign alu_b = (op == OP_ACS) ? bm_i : opb_i;

  acs_sat_add #(.W(W)) u_alu (
    .a   (a_val),
    .b   (alu_b),
    .sub (op == OP_SUB),
    .y   (alu_y)
  );

  acs_maxstar #(.W(W)) u_ms (
    .x (acc_q),
    .y (alu_y),
    .z (ms_y)
  );

  always_comb begin
    res_d  = res_q;
    acc_d  = acc_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    res_en = 1'b0;
    acs_en = 1'b0;
    case (op)
      OP_ADD, OP_SUB: begin
        res_d  = alu_y;
        res_en = 1'b1;
      end
      OP_ACS: begin
        res_d  = (cnt_q == '0) ? alu_y : ms_y;
        acc_d  = res_d;
        res_en = 1'b1;
        acs_en = 1'b1;
        if (cnt_q == CW'(GRP - 1)) begin
          cnt_d  = '0;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: ;
    endcase
    wr_sel = res_en ? dst_i : '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
    end else if (res_en) begin
      res_q <= res_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (acs_en) begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= done_d;
  end

  assign res_o  = res_q;
  assign done_o = done_q;

  AST_DONE_SPACED: assert property (@(posedge clk) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_FROM_ACS: assert property (@(posedge clk) disable iff (!rst_ni)
    done_o |-> ($past(op) == OP_ACS)); // R8
  AST_MERGE_FLOOR: assert property (@(posedge clk) disable iff (!rst_ni)
    (op == OP_ACS && cnt_q != '0) |=>
      ($signed(res_o) >= $past(acc_q) && $signed(res_o) >= $past(alu_y))); // R7
  AST_MERGE_CEIL: assert property (@(posedge clk) disable iff (!rst_ni)
    (op == OP_ACS && cnt_q != '0) |=>
      ($signed(res_o) <= $past(acc_q) + 3 || $signed(res_o) <= $past(alu_y) + 3)); // R7
  AST_NOP_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (op == OP_NOP) |=> ($stable(res_o) && !done_o)); // R9
  AST_ARITH_KEEPS_GROUP: assert property (@(posedge clk) disable iff (!rst_ni)
    (op == OP_ADD || op == OP_SUB) |=> ($stable(acc_q) && $stable(cnt_q))); // R10
endmodule

// File: tb/sim_acs_maxstar_unit.sv
`timescale 1ns/1ps
module sim_acs_maxstar_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] op_i, asel_i, dst_i;
  logic [9:0] opa_i, opb_i, bm_i;
  logic [9:0] res_o;
  logic       done_o;

  int checks = 0;
  int errors = 0;

  int mr [4];
  int macc, mcnt, mres;
  bit mdone;
  int ctab [8];

  always #10 clk = ~clk;

  acs_maxstar_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .asel_i(asel_i), .dst_i(dst_i),
    .opa_i(opa_i), .opb_i(opb_i), .bm_i(bm_i), .res_o(res_o), .done_o(done_o)
  );

  function automatic int sat(input int v);
    if (v > 511) return 511;
    if (v < -512) return -512;
    return v;
  endfunction

  function automatic int merge(input int v, input int t);
    int d, k, c, mx;
    d  = v - t;
    k  = (d >= 0) ? d : -d - 1;
    c  = (k <= 7) ? ctab[k] : 0;
    mx = (d >= 0) ? v : t;
    return sat(mx + c);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a falling edge; drives, advances the model, compares at the next falling edge.
  task automatic step(input int op, input int as, input int ds,
                      input int a, input int b, input int m);
    int av, raw, v;
    string tag;
    op_i = 2'(op); asel_i = 2'(as); dst_i = 2'(ds);
    opa_i = 10'(a); opb_i = 10'(b); bm_i = 10'(m);
    av  = (as == 0) ? a : mr[as];
    tag = "R9";
    mdone = 1'b0;
    v = mres;
    if (op == 1 || op == 2) begin
      raw = (op == 1) ? av + b : av - b;
      v = sat(raw);
      tag = (raw != v) ? "R4" : (as != 0) ? "R5" : (mcnt != 0) ? "R10" : (op == 1) ? "R2" : "R3";
    end else if (op == 3) begin
      raw = sat(av + m);
      if (mcnt == 0) begin v = raw; tag = "R6"; end
      else begin v = merge(macc, raw); tag = "R7"; end
      macc = v;
      if (mcnt == 3) begin mcnt = 0; mdone = 1'b1; end
      else mcnt++;
    end
    if (op != 0) begin
      mres = v;
      if (ds != 0) mr[ds] = v;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, $signed(res_o), mres);
    check("R8", int'(done_o), int'(mdone));
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL R8 watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++)
      ctab[i] = $rtoi(4.0 * $ln(1.0 + $exp(-(i + 0.5) / 4.0)) + 0.5);
    for (int i = 0; i < 4; i++) mr[i] = 0;
    macc = 0; mcnt = 0; mres = 0; mdone = 0;
    op_i = 0; asel_i = 0; dst_i = 0; opa_i = 0; opb_i = 0; bm_i = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports, then the registers through the add path
    check("R1", $signed(res_o), 0);
    check("R1", int'(done_o), 0);
    for (int r = 1; r <= 3; r++) begin
      step(1, r, 0, 0, 0, 0);
      check("R1", $signed(res_o), 0);
    end
    // R2 R3: arithmetic with register writes
    step(1, 0, 1, 100, 23, 0);
    step(2, 0, 2, -40, 15, 0);
    step(1, 1, 3, 0, -7, 0);
    step(2, 3, 0, 0, 50, 0);
    step(1, 2, 0, 0, 0, 0);
    // R4: both limits
    step(1, 0, 0, 500, 100, 0);
    step(2, 0, 0, -500, 100, 0);
    step(2, 0, 0, 0, -512, 0);
    step(1, 0, 0, -512, -1, 0);
    // R9: NOP holds
    step(0, 0, 1, 77, 77, 77);
    step(0, 0, 0, 1, 1, 1);
    step(1, 1, 0, 0, 0, 0);
    // R6 R7 R8: index edges on both signs of the difference
    step(3, 0, 0, 100, 0, 0);
    step(3, 0, 0, 100, 0, 0);
    step(3, 0, 0, 96, 0, 0);
    step(3, 0, 0, 112, 0, 0);
    step(3, 0, 0, 0, 0, 0);
    step(3, 0, 0, 9, 0, 0);
    step(3, 0, 1, 0, 0, 0);
    step(3, 0, 0, 30, 0, 0);
    // R10: arithmetic interleaved in a group, then R8 back-to-back groups
    step(3, 0, 0, 20, 5, 0);
    step(1, 0, 2, 1, 1, 0);
    step(3, 0, 0, 20, 4, 0);
    step(2, 0, 0, 3, 9, 0);
    step(3, 1, 0, 0, 0, 17);
    step(3, 0, 0, 510, 0, 5);
    step(3, 0, 0, 511, 0, 0);
    step(3, 0, 0, 511, 0, 0);
    step(3, 0, 0, -512, 0, -3);
    step(3, 0, 0, 7, 0, 0);
    step(3, 0, 3, -1, 0, 0);
    step(1, 3, 0, 0, 1, 0);
    // mixed stimulus
    for (int n = 0; n < 600; n++) begin
      int sop, a, b, m;
      sop = ($urandom % 8 < 5) ? 3 : int'($urandom % 3);
      a = int'($urandom % 1024) - 512;
      b = int'($urandom % 1024) - 512;
      m = int'($urandom % 64) - 32;
      if (n % 3 == 0) a = (a % 24);
      step(sop, int'($urandom % 4), int'($urandom % 4), a, b, m);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule